// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the serial clock of an I2C master from a fast system clock. A power-of-two prescaler derives a reference clock, and two 5-bit counts set how many reference cycles the clock spends high and low. The block adds a fixed number of overhead reference cycles to every phase. These cycles stand for the input synchroniser and the noise filter. There are four overhead cycles when the prescaler is bypassed and three otherwise. Programmed counts of zero act as one.

The line is open-drain. The block asserts an output-enable to pull SCL low and releases it for the high phase. After release it watches the line through a two-flop synchroniser and a one-cycle glitch filter. The high-phase count starts only once the line is seen high, so a slave that holds SCL low stretches the clock. A one-cycle strobe marks the end of each phase for the start/stop and data-shift logic around it.

The settings are captured only while the enable is low. The phase machine has four states:
- IDLE: line released. It moves to LOW on the first reference tick after enable.
- LOW: line pulled low. When its count expires it moves to HIGH if the filtered line is high, and to WAIT_HI if not.
- WAIT_HI: line released and counter held. It moves to HIGH on a reference tick that sees the filtered line high.
- HIGH: line released and counting. When its count expires it moves to LOW.

Dropping the enable returns the machine to IDLE from any state.

Top module: `scl_rate_gen`

## Requirements
- R1: The reference tick occurs once every 2^cks system clocks (cks 0 to 7), and phase boundaries fall only on reference ticks, so every phase length in system clocks is its reference-cycle length times 2^cks.
- R2: The low phase (scl_oe_o = 1) lasts brl_eff + 4 reference cycles when cks = 0 and brl_eff + 3 when cks is non-zero.
- R3: With the line seen high, the high phase (scl_oe_o = 0) lasts brh_eff + 4 reference cycles when cks = 0 and brh_eff + 3 otherwise.
- R4: Only bits [4:0] of brh_i and brl_i form the count; bits [7:5] have no effect; a count of 0 is used as 1 (brh_eff, brl_eff).
- R5: After the low phase the line stays released and the high count does not start until the two-flop-synchronised, filtered SCL reads high. With cks = 0, oe returns to 1 exactly brh_eff + 9 system clocks after scl_i rises.
- R6: A level on scl_i that lasts a single reference cycle does not change the filtered line and does not end a stretch.
- R7: Under reset, or one clock after en_i falls, scl_oe_o is 0, the machine is idle and no strobe fires.
- R8: cks_i, brh_i and brl_i are captured only while en_i is 0; changes while enabled have no effect on the running waveform.
- R9: low_end_o pulses for one clock as the low phase ends, and high_end_o pulses for one clock as the high phase ends; they never pulse together.
- R10: After en_i rises, the first phase is a low phase that begins on the first reference tick, 2^cks clocks after the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; settings captured while low |
| cks_i | input | 3 | Prescaler exponent, reference = clk / 2^cks |
| brh_i | input | 8 | High-phase count register, bits [4:0] used |
| brl_i | input | 8 | Low-phase count register, bits [4:0] used |
| scl_i | input | 1 | Sampled level of the SCL line |
| scl_oe_o | output | 1 | Open-drain enable, 1 pulls SCL low |
| low_end_o | output | 1 | One-clock strobe at the end of a low phase |
| high_end_o | output | 1 | One-clock strobe at the end of a high phase |

## Verification
The in-line assertions watch properties that hold on every cycle. The prescaler count stays within its limit and the captured settings stay frozen while enabled. The filter only moves to a level seen on two consecutive ticks, and the line is released after disable. The strobes are exclusive and track the oe edge, and the high state is entered only from a high filtered line. Exact phase lengths need the bench's scenarios: the effective count with its overhead, prescaler scaling, zero-count substitution, ignored upper bits, stretch latency and glitch rejection all show only in measured durations.

// File: rtl/sclgen_pkg.sv
`timescale 1ns/1ps
package sclgen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOW     = 2'd1,
        PH_WAIT_HI = 2'd2,
        PH_HIGH    = 2'd3
    } phase_e;

    // overhead reference cycles added to every phase
    localparam int OVH_DIRECT  = 4;   // prescaler bypassed
    localparam int OVH_DIVIDED = 3;   // prescaler active
    localparam int MIN_COUNT   = 1;   // smallest usable phase count

endpackage

// File: rtl/sclgen_prescale.sv
`timescale 1ns/1ps
module sclgen_prescale #(
    parameter int CKS_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CKS_W-1:0] cks_i,
    output logic             ref_tick_o
);
    localparam int DIV_W = (1 << CKS_W) - 1;
    localparam logic [DIV_W-1:0] ALL_ONES = '1;

    logic [DIV_W-1:0] div_cnt_q;
    logic [DIV_W-1:0] div_lim;

    always_comb begin
        div_lim    = ALL_ONES >> (DIV_W - int'(cks_i));
        ref_tick_o = run_i && (div_cnt_q == div_lim);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_cnt_q <= '0;
        end else if (!run_i || ref_tick_o) begin
            div_cnt_q <= '0;
        end else begin
            div_cnt_q <= div_cnt_q + 1'b1;
        end
    end

    // R1: divider never runs past the selected limit
    assert_div_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (div_cnt_q <= div_lim));

    // R1: while stopped no tick is issued
    assert_no_tick_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> !ref_tick_o);

endmodule

// File: rtl/sclgen_filter.sv
`timescale 1ns/1ps
module sclgen_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_tick_i,
    input  logic scl_i,
    output logic scl_filt_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   filt_q;
    logic                   sync_out;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    sync_q[g] <= 1'b1;
                end else if (g == 0) begin
                    sync_q[g] <= scl_i;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign sync_out = sync_q[SYNC_STAGES-1];

    // level accepted only when seen on two consecutive reference ticks
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b1;
            filt_q <= 1'b1;
        end else if (ref_tick_i) begin
            prev_q <= sync_out;
            if (sync_out == prev_q) begin
                filt_q <= sync_out;
            end
        end
    end

    assign scl_filt_o = filt_q;

    // R6: a change of the filtered level needs the same level on the previous tick
    assert_glitch_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(filt_q) |-> ($past(prev_q) == filt_q) && $past(ref_tick_i));

endmodule

// File: rtl/sclgen_phase_fsm.sv
`timescale 1ns/1ps
module sclgen_phase_fsm
    import sclgen_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int CKS_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             ref_tick_i,
    input  logic             scl_high_i,
    input  logic [CKS_W-1:0] cks_i,
    input  logic [CNT_W-1:0] brh_i,
    input  logic [CNT_W-1:0] brl_i,
    output logic             scl_oe_o,
    output logic             low_end_o,
    output logic             high_end_o
);
    localparam int PH_W = CNT_W + 1;

    phase_e          state_q, state_d;
    logic [PH_W-1:0] cnt_q, cnt_d;
    logic [PH_W-1:0] low_len, high_len;
    logic            direct;
    logic            low_fin, high_fin;

    function automatic logic [PH_W-1:0] phase_len(input logic [CNT_W-1:0] b,
                                                  input logic is_direct);
        logic [CNT_W-1:0] eff;
        eff = (b == '0) ? CNT_W'(MIN_COUNT) : b;
        return {1'b0, eff} + (is_direct ? PH_W'(OVH_DIRECT) : PH_W'(OVH_DIVIDED));
    endfunction

    always_comb begin
        direct   = (cks_i == '0);
        low_len  = phase_len(brl_i, direct);
        high_len = phase_len(brh_i, direct);
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        low_fin  = 1'b0;
        high_fin = 1'b0;
        if (!run_i) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
        end else if (ref_tick_i) begin
            unique case (state_q)
                PH_IDLE: begin
                    state_d = PH_LOW;
                    cnt_d   = '0;
                end
                PH_LOW: begin
                    if (cnt_q == low_len - 1'b1) begin
                        low_fin = 1'b1;
                        cnt_d   = '0;
                        state_d = scl_high_i ? PH_HIGH : PH_WAIT_HI;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_WAIT_HI: begin
                    if (scl_high_i) begin
                        state_d = PH_HIGH;
                        cnt_d   = '0;
                    end
                end
                PH_HIGH: begin
                    if (cnt_q == high_len - 1'b1) begin
                        high_fin = 1'b1;
                        cnt_d    = '0;
                        state_d  = PH_LOW;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = PH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            low_end_o  <= 1'b0;
            high_end_o <= 1'b0;
        end else begin
            low_end_o  <= low_fin;
            high_end_o <= high_fin;
        end
    end

    assign scl_oe_o = (state_q == PH_LOW);

    assert_release_on_disable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!scl_oe_o && state_q == PH_IDLE));

    assert_strobe_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({low_end_o, high_end_o}));

    assert_low_end_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_end_o |-> ($past(scl_oe_o) && !scl_oe_o));

    assert_high_end_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        high_end_o |-> (!$past(scl_oe_o) && scl_oe_o));

    assert_high_needs_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PH_HIGH && $past(state_q) != PH_HIGH) |-> $past(scl_high_i));

    assert_low_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PH_LOW) |-> (cnt_q < low_len));

endmodule

// File: rtl/scl_rate_gen.sv
`timescale 1ns/1ps
module scl_rate_gen #(
    parameter int CKS_W       = 3,
    parameter int CNT_W       = 5,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CKS_W-1:0] cks_i,
    input  logic [REG_W-1:0] brh_i,
    input  logic [REG_W-1:0] brl_i,
    input  logic             scl_i,
    output logic             scl_oe_o,
    output logic             low_end_o,
    output logic             high_end_o
);
    logic [CKS_W-1:0] cks_q;
    logic [CNT_W-1:0] brh_q, brl_q;
    logic             ref_tick;
    logic             scl_filt;
    logic             cfg_unused_bits;

    // fixed-one register bits carry no count information
    assign cfg_unused_bits = &{brh_i[REG_W-1:CNT_W], brl_i[REG_W-1:CNT_W]};

    // settings follow the inputs only while the block is held stopped
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cks_q <= '0;
            brh_q <= '0;
            brl_q <= '0;
        end else if (!en_i) begin
            cks_q <= cks_i;
            brh_q <= brh_i[CNT_W-1:0];
            brl_q <= brl_i[CNT_W-1:0];
        end
    end

    assert_cfg_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && $past(en_i)) |-> ($stable(cks_q) && $stable(brh_q) && $stable(brl_q)));

    sclgen_prescale #(.CKS_W(CKS_W)) u_prescale (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (en_i),
        .cks_i      (cks_q),
        .ref_tick_o (ref_tick)
    );

    sclgen_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ref_tick_i (ref_tick),
        .scl_i      (scl_i),
        .scl_filt_o (scl_filt)
    );

    sclgen_phase_fsm #(.CNT_W(CNT_W), .CKS_W(CKS_W)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (en_i),
        .ref_tick_i (ref_tick),
        .scl_high_i (scl_filt),
        .cks_i      (cks_q),
        .brh_i      (brh_q),
        .brl_i      (brl_q),
        .scl_oe_o   (scl_oe_o),
        .low_end_o  (low_end_o),
        .high_end_o (high_end_o)
    );

endmodule

// File: tb/scl_rate_gen_tb_top.sv
`timescale 1ns/1ps
module scl_rate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] cks = 3'd0;
    logic [7:0] brh = 8'hE1;
    logic [7:0] brl = 8'hE1;
    logic       scl = 1'b1;
    logic       oe, lend, hend;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    scl_rate_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cks_i(cks),
        .brh_i(brh), .brl_i(brl), .scl_i(scl),
        .scl_oe_o(oe), .low_end_o(lend), .high_end_o(hend)
    );

    typedef struct packed {
        logic [2:0] c;
        logic [7:0] h;
        logic [7:0] l;
        int         lo;
        int         hi;
    } vec_t;

    // expected lengths in system clocks: (eff + overhead) << cks
    localparam vec_t VECS [6] = '{
        '{3'd0, 8'h05, 8'h07, 11,  9},
        '{3'd1, 8'h1F, 8'h1F, 68,  68},
        '{3'd2, 8'h00, 8'h00, 16,  16},
        '{3'd0, 8'hE1, 8'hE2, 6,   5},
        '{3'd7, 8'h02, 8'h03, 768, 640},
        '{3'd3, 8'hFF, 8'h10, 152, 272}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic program_cfg(input logic [2:0] c, input logic [7:0] h, input logic [7:0] l);
        @(negedge clk);
        en  = 1'b0;
        cks = c;
        brh = h;
        brl = l;
        repeat (3) @(negedge clk);
    endtask

    // measure one full low phase then one full high phase
    task automatic measure(output int lo, output int hi, output bit le, output bit he);
        int guard = 0;
        lo = 0;
        hi = 0;
        while (!oe && guard < 20000) begin @(negedge clk); guard++; end
        while (oe && lo < 20000) begin lo++; @(negedge clk); end
        le = lend;
        while (!oe && hi < 20000) begin hi++; @(negedge clk); end
        he = hend;
    endtask

    initial begin
        int lo, hi, k, bad;
        bit le, he;
        repeat (3) @(negedge clk);
        check(!oe && !lend && !hend, "R7 reset state", int'(oe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!oe, "R7 idle after reset", int'(oe), 0);

        for (int i = 0; i < 6; i++) begin
            program_cfg(VECS[i].c, VECS[i].h, VECS[i].l);
            en = 1'b1;
            measure(lo, hi, le, he);
            check(lo == VECS[i].lo, $sformatf("R2 R1 R4 low length vec %0d", i), lo, VECS[i].lo);
            check(hi == VECS[i].hi, $sformatf("R3 R1 R4 high length vec %0d", i), hi, VECS[i].hi);
            check(le, $sformatf("R9 low_end strobe vec %0d", i), int'(le), 1);
            check(he, $sformatf("R9 high_end strobe vec %0d", i), int'(he), 1);
        end

        // R10: first low phase starts on first reference tick
        program_cfg(3'd2, 8'h05, 8'h07);
        en = 1'b1;
        k = 0;
        while (!oe && k < 100) begin @(negedge clk); k++; end
        check(k == 4, "R10 first low phase start", k, 4);

        // R8: changes while enabled are ignored
        program_cfg(3'd0, 8'h05, 8'h07);
        en = 1'b1;
        while (!oe) @(negedge clk);
        brl = 8'h14;
        brh = 8'h09;
        cks = 3'd3;
        while (oe) @(negedge clk);
        measure(lo, hi, le, he);
        check(lo == 11, "R8 low unchanged while enabled", lo, 11);
        check(hi == 9, "R8 high unchanged while enabled", hi, 9);

        // R7: disable releases the line at once
        while (!oe) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(!oe, "R7 release on disable", int'(oe), 0);
        bad = 0;
        repeat (20) begin @(negedge clk); if (oe || lend || hend) bad++; end
        check(bad == 0, "R7 quiet while disabled", bad, 0);

        // R5 / R6: stretching and glitch rejection, cks = 0
        program_cfg(3'd0, 8'h05, 8'h07);
        scl = 1'b1;
        en  = 1'b1;
        while (!oe) @(negedge clk);
        scl = 1'b0;
        while (oe) @(negedge clk);
        bad = 0;
        repeat (40) begin @(negedge clk); if (oe) bad++; end
        check(bad == 0, "R5 released while slave holds low", bad, 0);
        scl = 1'b1;
        @(negedge clk);
        scl = 1'b0;
        bad = 0;
        repeat (30) begin @(negedge clk); if (oe) bad++; end
        check(bad == 0, "R6 one-cycle glitch ignored", bad, 0);
        scl = 1'b1;
        k = 0;
        while (!oe && k < 200) begin @(posedge clk); k++; @(negedge clk); end
        check(k == 14, "R5 high count after line seen high", k, 14);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule